// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

This block is a single-clock synchronous static RAM with a registered front end and a pipelined read path. Every address, control and write-data input is captured on the rising clock edge. An access begins when one of two address strobes is asserted with the device selected: a processor-side strobe or a controller-side strobe. Each strobe has its own rules for priority and masking. After a burst has started, a step input walks a 2-bit burst counter through four consecutive word addresses, or holds the current address to insert a wait state.

A static input chooses the burst order. In linear order the two low address bits increment and wrap. In interleaved order the two low bits are XORed with the counter value. Writes can cover the whole word through a global write, or only selected byte lanes. Each lane holds eight data bits plus one parity bit.

Read data passes through an output register and appears one cycle after the access. The output drive drops one cycle after a deselect. An asynchronous output-enable input can force the drive off at any time. The array depth and the lane count and width are parameters.

Top module: `psram_top`

## Requirements
- R1: After a synchronous reset the block is deselected and `rdata_drive` is 0, with `rdata_o` at 0.
- R2: A read addressed at clock edge n appears on `rdata_o` with `rdata_drive` = 1 after edge n+1, and not after edge n.
- R3: The controller-side strobe low, with the block selected (`sel_n`=0, `sel_hi`=1, `sel_lo_n`=0), starts an access at `addr_i`. If write controls are active on that edge, `wdata_i` is committed to that address on the same edge, and later reads return it.
- R4: The processor-side strobe low with `sel_n`=0 always starts a read: write controls on that edge are ignored. A write to the start address is done by asserting write controls on the next edge with `step_n`=1.
- R5: With `sel_n`=1, a low processor-side strobe is ignored and the edge acts as a burst-continue cycle. With `sel_n`=1 and the controller-side strobe low, the block deselects.
- R6: `sel_hi` and `sel_lo_n` matter only on edges with an effective strobe. A strobe with `sel_hi`=0 or `sel_lo_n`=1 deselects the block; without a strobe they have no effect.
- R7: With both strobes inactive during a burst, `step_n`=0 advances the counter by one and `step_n`=1 repeats the current address (wait state). Writes in such cycles go to the resulting address.
- R8: With `interleave_i`=0, burst addresses keep the upper address bits and set the two low bits to (start + k) mod 4 for k = 0..3.
- R9: With `interleave_i`=1, the two low burst address bits are start XOR k for k = 0..3.
- R10: Byte-lane decode works as follows:
  - `all_wr_n`=0 writes every lane.
  - Otherwise, `lane_en_n`=0 writes lane i where `lane_wr_n[i]`=0.
  - Lane i is data bits [9i+8:9i], and bit 9i+8 is that lane's parity bit.
  - `lane_en_n`=1 gives a read even if `lane_wr_n` bits are low.
- R11: `rdata_drive` is 1 only in the cycle after a read access. After a deselect or a write edge, the drive is 0 from the following cycle.
- R12: `out_en_n`=1 forces `rdata_drive` to 0 and `rdata_o` to 0 at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Word address; two low bits seed the burst counter |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst step, active low; high holds address |
| interleave_i | input | 1 | Static burst order: 1 interleaved, 0 linear |
| sel_n | input | 1 | Primary select, active low; masks processor strobe |
| sel_hi | input | 1 | Secondary select, active high |
| sel_lo_n | input | 1 | Secondary select, active low |
| all_wr_n | input | 1 | Global write of every lane, active low |
| lane_en_n | input | 1 | Enables per-lane write controls, active low |
| lane_wr_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Registered read data, 0 when not driven |
| rdata_drive | output | 1 | Output pad drive enable (high impedance when 0) |

## Verification
Two overlaps are provoked. In the first, a write edge directly follows a read edge, so the output register presents the earlier read while the array commits the write. The bench judges this by the read showing the old word, then the drive dropping for one cycle, then a re-read returning the new word. In the second, a processor-side strobe arrives with the primary select high while a burst is running, so masking and burst continuation fall on the same edge. The bench judges it by the output keeping the burst's word rather than the word at the strobed address. It also applies a deselect on the edge right after a read and expects exactly one more driven cycle.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [1:0] {
        OP_CONT  = 2'd0,
        OP_START = 2'd1,
        OP_DESEL = 2'd2
    } op_e;

    // Low two address bits of burst beat `step` from the seed bits.
    function automatic logic [1:0] burst_low(input logic interleave,
                                             input logic [1:0] seed,
                                             input logic [1:0] step);
        logic [1:0] sum;
        sum = seed + step;
        return interleave ? (seed ^ step) : sum;
    endfunction

endpackage

// File: rtl/psram_decode.sv
module psram_decode
    import psram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             strobe_cpu_n,
    input  logic             strobe_ctl_n,
    input  logic             sel_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic             all_wr_n,
    input  logic             lane_en_n,
    input  logic [LANES-1:0] lane_wr_n,
    output op_e              op,
    output logic [LANES-1:0] lane_we
);

    logic             sec_ok;
    logic [LANES-1:0] wr_req;

    always_comb begin
        sec_ok = sel_hi & ~sel_lo_n;
        if (!all_wr_n) begin
            wr_req = '1;
        end else if (!lane_en_n) begin
            wr_req = ~lane_wr_n;
        end else begin
            wr_req = '0;
        end

        if (!strobe_cpu_n && !sel_n) begin
            // processor-side strobe: always a read start
            op      = sec_ok ? OP_START : OP_DESEL;
            lane_we = '0;
        end else if (!strobe_ctl_n) begin
            op      = (!sel_n && sec_ok) ? OP_START : OP_DESEL;
            lane_we = (!sel_n && sec_ok) ? wr_req : '0;
        end else begin
            op      = OP_CONT;
            lane_we = wr_req;
        end
    end

endmodule

// File: rtl/psram_burst.sv
module psram_burst
    import psram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic              interleave,
    input  logic              step_n,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_en
);

    localparam int HI_W = ADDR_W - 2;

    typedef struct packed {
        logic            active;
        logic [HI_W-1:0] hi;
        logic [1:0]      seed;
        logic [1:0]      step;
    } bstate_t;

    bstate_t state_d, state_q;

    always_comb begin
        state_d  = state_q;
        acc_en   = 1'b0;
        acc_addr = {state_q.hi, burst_low(interleave, state_q.seed, state_q.step)};
        case (op)
            OP_START: begin
                state_d.active = 1'b1;
                state_d.hi     = addr_i[ADDR_W-1:2];
                state_d.seed   = addr_i[1:0];
                state_d.step   = 2'd0;
                acc_en         = 1'b1;
                acc_addr       = addr_i;
            end
            OP_DESEL: begin
                state_d.active = 1'b0;
            end
            default: begin
                if (state_q.active) begin
                    state_d.step = state_q.step + {1'b0, ~step_n};
                    acc_en       = 1'b1;
                    acc_addr     = {state_q.hi,
                                    burst_low(interleave, state_q.seed, state_d.step)};
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/psram_array.sv
module psram_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_lane,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lane[g]) begin
                cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/psram_top.sv
module psram_top
    import psram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    strobe_cpu_n,
    input  logic                    strobe_ctl_n,
    input  logic                    step_n,
    input  logic                    interleave_i,
    input  logic                    sel_n,
    input  logic                    sel_hi,
    input  logic                    sel_lo_n,
    input  logic                    all_wr_n,
    input  logic                    lane_en_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    out_en_n,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    rdata_drive
);

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic              rd_pend;
        logic [ADDR_W-1:0] rd_addr;
        logic              out_v;
        logic [DATA_W-1:0] out_data;
    } pstate_t;

    op_e               op;
    logic [LANES-1:0]  lane_we;
    logic [LANES-1:0]  wr_lane;
    logic [ADDR_W-1:0] acc_addr;
    logic              acc_en;
    logic [DATA_W-1:0] rd_data;
    logic              out_live;
    pstate_t           state_d, state_q;

    psram_decode #(.LANES(LANES)) u_decode (
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .sel_n        (sel_n),
        .sel_hi       (sel_hi),
        .sel_lo_n     (sel_lo_n),
        .all_wr_n     (all_wr_n),
        .lane_en_n    (lane_en_n),
        .lane_wr_n    (lane_wr_n),
        .op           (op),
        .lane_we      (lane_we)
    );

    psram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .interleave (interleave_i),
        .step_n     (step_n),
        .addr_i     (addr_i),
        .acc_addr   (acc_addr),
        .acc_en     (acc_en)
    );

    assign wr_lane = acc_en ? lane_we : '0;

    psram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .wr_lane (wr_lane),
        .wr_addr (acc_addr),
        .wr_data (wdata_i),
        .rd_addr (state_q.rd_addr),
        .rd_data (rd_data)
    );

    always_comb begin
        state_d          = state_q;
        state_d.rd_pend  = acc_en & ~(|lane_we);
        state_d.rd_addr  = acc_addr;
        state_d.out_v    = state_q.rd_pend;
        state_d.out_data = state_q.rd_pend ? rd_data : state_q.out_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_live    = state_q.out_v;
    assign rdata_drive = out_live & ~out_en_n;
    assign rdata_o     = rdata_drive ? state_q.out_data : '0;

endmodule

// File: rtl/psram_checker.sv
module psram_checker (
    input logic clk,
    input logic rst,
    input logic strobe_cpu_n,
    input logic strobe_ctl_n,
    input logic sel_n,
    input logic sel_hi,
    input logic sel_lo_n,
    input logic all_wr_n,
    input logic out_live,
    input logic rdata_drive
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !rdata_drive);

    assert_cpu_read_R4: assert property (@(posedge clk) disable iff (rst)
        (!strobe_cpu_n && !sel_n && sel_hi && !sel_lo_n) |=> ##1 out_live);

    assert_masked_desel_R5: assert property (@(posedge clk) disable iff (rst)
        (sel_n && !strobe_ctl_n) |=> ##1 !out_live);

    assert_sec_desel_R6: assert property (@(posedge clk) disable iff (rst)
        (((!strobe_cpu_n && !sel_n) || !strobe_ctl_n) && (!sel_hi || sel_lo_n))
        |=> ##1 !out_live);

    assert_write_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!strobe_ctl_n && strobe_cpu_n && !sel_n && sel_hi && !sel_lo_n && !all_wr_n)
        |=> ##1 !out_live);

endmodule

bind psram_top psram_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .sel_n        (sel_n),
    .sel_hi       (sel_hi),
    .sel_lo_n     (sel_lo_n),
    .all_wr_n     (all_wr_n),
    .out_live     (out_live),
    .rdata_drive  (rdata_drive)
);

// File: tb/psram_top_bench.sv
`timescale 1ns/1ps
module psram_top_bench;

    localparam int AW = 4;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic          strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, step_n = 1'b1;
    logic          interleave_i = 1'b0;
    logic          sel_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
    logic          all_wr_n = 1'b1, lane_en_n = 1'b1;
    logic [NL-1:0] lane_wr_n = '1;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_o;
    logic          rdata_drive;

    int vectors = 0;
    int fails   = 0;
    logic [DW-1:0] model [16];

    always #2.5 clk = ~clk;

    psram_top #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_psram_top (
        .clk(clk), .rst(rst), .addr_i(addr_i),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .step_n(step_n),
        .interleave_i(interleave_i), .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .all_wr_n(all_wr_n), .lane_en_n(lane_en_n), .lane_wr_n(lane_wr_n),
        .out_en_n(out_en_n), .wdata_i(wdata_i), .rdata_o(rdata_o), .rdata_drive(rdata_drive)
    );

    function automatic logic [DW-1:0] pat(input int k);
        return {9'(k + 1), 9'(k * 5) ^ 9'h155, 9'(k * 3), 9'(~k)};
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_out(input string tag, input logic drv, input logic [DW-1:0] exp);
        check({tag, " drive"}, {{(DW-1){1'b0}}, rdata_drive}, {{(DW-1){1'b0}}, drv});
        if (drv) check({tag, " data"}, rdata_o, exp);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; step_n = 1'b1;
        all_wr_n = 1'b1; lane_en_n = 1'b1; lane_wr_n = '1;
        sel_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
    endtask

    task automatic desel();
        idle(); sel_n = 1'b1; strobe_ctl_n = 1'b0;
        cyc();
        idle();
        cyc();
    endtask

    task automatic ctl_write(input int a, input logic [DW-1:0] d);
        idle(); strobe_ctl_n = 1'b0; all_wr_n = 1'b0; addr_i = AW'(a); wdata_i = d;
        cyc();
        model[a] = d;
        idle();
    endtask

    task automatic read_check(input string tag, input int a);
        idle(); strobe_ctl_n = 1'b0; addr_i = AW'(a);
        cyc();
        idle();
        cyc();
        check_out(tag, 1'b1, model[a]);
        desel();
    endtask

    task automatic t_reset();
        check_out("R1 after reset", 1'b0, '0);
        check("R1 data zero", rdata_o, '0);
        cyc();
        check_out("R1 idle", 1'b0, '0);
    endtask

    task automatic t_write_read();
        ctl_write(5, pat(50));
        idle(); strobe_ctl_n = 1'b0; addr_i = 4'd5;
        cyc();
        check_out("R2 not yet after edge n", 1'b0, '0);
        idle();
        cyc();
        check_out("R3 R2 read back", 1'b1, pat(50));
        desel();
    endtask

    task automatic t_bytes();
        logic [DW-1:0] nw, mg;
        nw = {4{9'h1FF}} ^ {9'h000, 9'h0A5, 9'h000, 9'h05A};
        mg = model[5];
        for (int i = 0; i < NL; i++)
            if (i == 0 || i == 2) mg[i*LW +: LW] = nw[i*LW +: LW];
        idle(); strobe_ctl_n = 1'b0; lane_en_n = 1'b0; lane_wr_n = 4'b1010;
        addr_i = 4'd5; wdata_i = nw;
        cyc();
        model[5] = mg;
        idle();
        cyc();
        check_out("R11 no drive after write", 1'b0, '0);
        desel();
        read_check("R10 lanes 0,2 with parity", 5);
        // lane_en_n high with lane bits low: a read
        idle(); strobe_ctl_n = 1'b0; lane_en_n = 1'b1; lane_wr_n = 4'b0000;
        addr_i = 4'd5; wdata_i = pat(99);
        cyc();
        idle();
        cyc();
        check_out("R10 lane_en_n high reads", 1'b1, mg);
        desel();
        read_check("R10 memory unchanged", 5);
    endtask

    task automatic t_burst(input string tag, input logic il, input int start,
                           input int e0, input int e1, input int e2, input int e3);
        int exp [4];
        exp[0] = e0; exp[1] = e1; exp[2] = e2; exp[3] = e3;
        interleave_i = il;
        idle(); strobe_cpu_n = 1'b0; addr_i = AW'(start);
        cyc();
        idle(); step_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            cyc();
            check_out($sformatf("%s beat %0d", tag, k), 1'b1, model[exp[k]]);
        end
        desel();
        interleave_i = 1'b0;
    endtask

    task automatic t_wait();
        idle(); strobe_ctl_n = 1'b0; addr_i = 4'd8;
        cyc();
        idle();
        cyc();
        check_out("R7 hold 1", 1'b1, model[8]);
        cyc();
        check_out("R7 hold 2", 1'b1, model[8]);
        step_n = 1'b0;
        cyc();
        check_out("R7 before step", 1'b1, model[8]);
        cyc();
        check_out("R7 after step", 1'b1, model[9]);
        desel();
    endtask

    task automatic t_mask();
        idle(); strobe_ctl_n = 1'b0; addr_i = 4'd8;
        cyc();
        idle(); sel_n = 1'b1; strobe_cpu_n = 1'b0; addr_i = 4'd5;
        cyc();
        check_out("R5 masked strobe 1", 1'b1, model[8]);
        cyc();
        check_out("R5 masked strobe keeps burst", 1'b1, model[8]);
        idle(); sel_n = 1'b1; strobe_ctl_n = 1'b0;
        cyc();
        check_out("R11 one more cycle after deselect", 1'b1, model[8]);
        idle();
        cyc();
        check_out("R5 R11 deselected", 1'b0, '0);
        step_n = 1'b0;
        cyc();
        check_out("R5 stays deselected", 1'b0, '0);
        idle();
    endtask

    task automatic t_secondary();
        idle(); strobe_ctl_n = 1'b0; addr_i = 4'd9;
        cyc();
        idle(); sel_hi = 1'b0;
        cyc();
        check_out("R6 no strobe 1", 1'b1, model[9]);
        cyc();
        check_out("R6 secondary ignored", 1'b1, model[9]);
        strobe_cpu_n = 1'b0;
        cyc();
        check_out("R6 deselect edge", 1'b1, model[9]);
        idle();
        cyc();
        check_out("R6 sel_hi deselect", 1'b0, '0);
        idle(); strobe_ctl_n = 1'b0; addr_i = 4'd9;
        cyc();
        idle(); strobe_ctl_n = 1'b0; sel_lo_n = 1'b1;
        cyc();
        idle();
        cyc();
        check_out("R6 sel_lo_n deselect", 1'b0, '0);
    endtask

    task automatic t_cpu_write();
        ctl_write(4, pat(40));
        desel();
        idle(); strobe_cpu_n = 1'b0; all_wr_n = 1'b0; addr_i = 4'd4; wdata_i = pat(41);
        cyc();
        idle();
        cyc();
        check_out("R4 strobe edge read, write ignored", 1'b1, pat(40));
        all_wr_n = 1'b0; wdata_i = pat(42);
        cyc();
        model[4] = pat(42);
        check_out("R4 read before write", 1'b1, pat(40));
        idle();
        cyc();
        check_out("R11 write edge not driven", 1'b0, '0);
        cyc();
        check_out("R4 follow-up write landed", 1'b1, pat(42));
        desel();
    endtask

    task automatic t_oe();
        idle(); strobe_ctl_n = 1'b0; addr_i = 4'd8;
        cyc();
        idle();
        cyc();
        out_en_n = 1'b1;
        #1;
        check_out("R12 forced off", 1'b0, '0);
        check("R12 data zero", rdata_o, '0);
        out_en_n = 1'b0;
        #1;
        check_out("R12 restored", 1'b1, model[8]);
        desel();
    endtask

    task automatic t_burst_write();
        idle(); strobe_ctl_n = 1'b0; all_wr_n = 1'b0; addr_i = 4'd12; wdata_i = pat(120);
        cyc();
        model[12] = pat(120);
        idle(); step_n = 1'b0; all_wr_n = 1'b0; wdata_i = pat(130);
        cyc();
        model[13] = pat(130);
        wdata_i = pat(140);
        cyc();
        model[14] = pat(140);
        desel();
        read_check("R7 R3 burst write 13", 13);
        read_check("R7 R3 burst write 14", 14);
        read_check("R3 burst write 12", 12);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_bytes();
        for (int a = 8; a < 12; a++) ctl_write(a, pat(a * 7));
        desel();
        t_burst("R8 R2 linear from 10", 1'b0, 10, 10, 11, 8, 9);
        t_burst("R9 interleaved from 9", 1'b1, 9, 9, 8, 11, 10);
        t_burst("R9 interleaved from 10", 1'b1, 10, 10, 11, 8, 9);
        t_burst("R8 linear from 9", 1'b0, 9, 9, 10, 11, 8);
        t_wait();
        t_mask();
        t_secondary();
        t_cpu_write();
        t_oe();
        t_burst_write();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule